// File: doc/BRIEF.md
# Clock Victim Selector

This block tracks a use flag and a modified flag for every physical frame in a fixed pool and, on request, names the frame to evict using a circular clock policy. Frame accesses set the use flag of the touched frame, and write accesses also set its modified flag. A scan starts at the hand and inspects one frame per clock. The first lap accepts only a frame that is unused and unmodified, and it clears the use flag of every used frame it passes. The second lap accepts the first unused frame whatever its modified flag. If accesses keep every frame in use, the frame under the hand is taken after two full laps.

When the scan ends, the block pulses a completion strobe with the chosen frame index and that frame's modified flag, so the caller knows whether a write-back is needed. The hand is left on the frame after the victim. The victim's flags are cleared for the page that will replace it. The page transfer itself belongs to the surrounding logic.

Top module: `clk_repl_sel`

## Requirements
- R1: After reset the hand is 0, `busy` and `done` are low, and every frame's use and modified flags are 0.
- R2: A cycle with `touch_valid` high sets the use flag of frame `touch_idx`. If `touch_write` is also 1, that frame's modified flag is set as well.
- R3: A `req` that is sampled while `busy` is low starts a scan, and `busy` is high from the next cycle. The frame under the hand is inspected on each busy clock, and the hand is unchanged while idle. A `req` sampled while `busy` is high has no effect.
- R4: During the first lap of NUM_FRAMES inspections, a frame with both flags 0 is chosen. A frame whose use flag is 1 has that flag cleared and is passed. A frame with use 0 and modified 1 is passed unchanged.
- R5: During the second lap of NUM_FRAMES inspections, the first frame with use flag 0 is chosen, and `victim_dirty` reports its modified flag.
- R6: If both laps end without a choice, the frame under the hand at inspection 2*NUM_FRAMES+1 is chosen. `busy` never lasts more than 2*NUM_FRAMES+1 cycles.
- R7: `done` is high for exactly one cycle per scan, with `busy` low. In that cycle `victim_idx` and `victim_dirty` are valid, and the hand equals (victim+1) mod NUM_FRAMES.
- R8: When a frame is chosen, its use and modified flags are cleared, so it becomes a clean candidate for the next scan.
- R9: An access in the same cycle as a scan clear of its frame takes priority, and the use flag ends at 1. When the access hits a frame as it is chosen, the use flag ends at 1. The modified flag ends at 1 if the access is a write and at 0 if it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| touch_valid | input | 1 | A frame is accessed this cycle |
| touch_idx | input | IDX_W | Index of the accessed frame |
| touch_write | input | 1 | The access modifies the frame |
| req | input | 1 | Request a victim scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle strobe: victim selected |
| victim_idx | output | IDX_W | Index of the selected frame |
| victim_dirty | output | 1 | Selected frame's modified flag |
| hand_idx | output | IDX_W | Current hand position |

## Verification
The most delicate overlap is an access that lands on the frame the hand is inspecting. In that one cycle, the scan wants to clear the frame's use flag, or clear both flags of the chosen victim, while the access wants to set them. The bench provokes this by touching the frame under the hand on exactly its inspection edge. It first does this once in a lap where the result steers the second-lap choice to the following frame. It then does it on every edge of a scan, which forces the fallback after two laps and also hits the victim as it is chosen. The judgement comes from which frame the scan names and from the outcome of later scans, which the bench compares each clock with its own behavioural model.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAN = 2'd1,
        PH_ANY   = 2'd2,
        PH_FORCE = 2'd3
    } phase_e;

endpackage

// File: rtl/clk_repl_step.sv
module clk_repl_step #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    always_comb begin
        if (cur == LAST) nxt = '0;
        else             nxt = cur + 1'b1;
    end
endmodule

// File: rtl/clk_repl_judge.sv
module clk_repl_judge
    import clk_repl_pkg::*;
(
    input  phase_e phase,
    input  logic   use_bit,
    input  logic   mod_bit,
    output logic   take
);
    always_comb begin
        unique case (phase)
            PH_CLEAN: take = !use_bit && !mod_bit;
            PH_ANY:   take = !use_bit;
            PH_FORCE: take = 1'b1;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/clk_repl_bits.sv
module clk_repl_bits #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  set_mod,
    input  logic                  pass_clr_en,
    input  logic [IDX_W-1:0]      pass_idx,
    input  logic                  vic_clr_en,
    input  logic [IDX_W-1:0]      vic_idx,
    output logic [NUM_FRAMES-1:0] use_vec,
    output logic [NUM_FRAMES-1:0] mod_vec
);
    typedef struct packed {
        logic [NUM_FRAMES-1:0] use_f;
        logic [NUM_FRAMES-1:0] mod_f;
    } bits_t;

    bits_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (set_en && set_idx == IDX_W'(i)) begin
                st_d.use_f[i] = 1'b1;
            end else if ((pass_clr_en && pass_idx == IDX_W'(i)) ||
                         (vic_clr_en && vic_idx == IDX_W'(i))) begin
                st_d.use_f[i] = 1'b0;
            end
            if (set_en && set_mod && set_idx == IDX_W'(i)) begin
                st_d.mod_f[i] = 1'b1;
            end else if (vic_clr_en && vic_idx == IDX_W'(i)) begin
                st_d.mod_f[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign use_vec = st_q.use_f;
    assign mod_vec = st_q.mod_f;
endmodule

// File: rtl/clk_repl_sel.sv
module clk_repl_sel
    import clk_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_write,
    input  logic             req,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty,
    output logic [IDX_W-1:0] hand_idx
);
    localparam logic [IDX_W-1:0] LAP_END = IDX_W'(NUM_FRAMES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] hand;
        logic [IDX_W-1:0] cnt;
        logic             done;
        logic [IDX_W-1:0] vidx;
        logic             vdirty;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_FRAMES-1:0] use_vec;
    logic [NUM_FRAMES-1:0] mod_vec;
    logic                  cur_use;
    logic                  cur_mod;
    logic                  take;
    logic [IDX_W-1:0]      hand_nxt;
    logic                  pass_clr_en;
    logic                  vic_clr_en;

    assign cur_use = use_vec[ctl_q.hand];
    assign cur_mod = mod_vec[ctl_q.hand];

    clk_repl_step #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_step (
        .cur (ctl_q.hand),
        .nxt (hand_nxt)
    );

    clk_repl_judge u_judge (
        .phase   (ctl_q.phase),
        .use_bit (cur_use),
        .mod_bit (cur_mod),
        .take    (take)
    );

    clk_repl_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (touch_valid),
        .set_idx     (touch_idx),
        .set_mod     (touch_write),
        .pass_clr_en (pass_clr_en),
        .pass_idx    (ctl_q.hand),
        .vic_clr_en  (vic_clr_en),
        .vic_idx     (ctl_q.hand),
        .use_vec     (use_vec),
        .mod_vec     (mod_vec)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        pass_clr_en = 1'b0;
        vic_clr_en  = 1'b0;
        if (ctl_q.phase == PH_IDLE) begin
            if (req) begin
                ctl_d.phase = PH_CLEAN;
                ctl_d.cnt   = '0;
            end
        end else if (take) begin
            ctl_d.done   = 1'b1;
            ctl_d.vidx   = ctl_q.hand;
            ctl_d.vdirty = cur_mod;
            ctl_d.hand   = hand_nxt;
            ctl_d.phase  = PH_IDLE;
            vic_clr_en   = 1'b1;
        end else begin
            pass_clr_en = cur_use;
            ctl_d.hand  = hand_nxt;
            if (ctl_q.cnt == LAP_END) begin
                ctl_d.cnt   = '0;
                ctl_d.phase = (ctl_q.phase == PH_CLEAN) ? PH_ANY : PH_FORCE;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, hand: '0, cnt: '0, done: 1'b0,
                       vidx: '0, vdirty: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy         = (ctl_q.phase != PH_IDLE);
    assign done         = ctl_q.done;
    assign victim_idx   = ctl_q.vidx;
    assign victim_dirty = ctl_q.vdirty;
    assign hand_idx     = ctl_q.hand;
endmodule

// File: rtl/clk_repl_chk.sv
module clk_repl_chk #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  touch_valid,
    input logic [IDX_W-1:0]      touch_idx,
    input logic                  touch_write,
    input logic                  req,
    input logic                  busy,
    input logic                  done,
    input logic [IDX_W-1:0]      victim_idx,
    input logic [IDX_W-1:0]      hand_idx,
    input logic [NUM_FRAMES-1:0] use_vec,
    input logic [NUM_FRAMES-1:0] mod_vec
);
    localparam int LIMIT = 2 * NUM_FRAMES + 1;

    logic [31:0] run_q;
    logic [IDX_W-1:0] after_victim;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    assign after_victim = (victim_idx == IDX_W'(NUM_FRAMES - 1)) ? '0 : victim_idx + 1'b1;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hand_idx == after_victim); // R7
    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy); // R3
    AST_IDLE_HAND: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(hand_idx)); // R3
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < 32'(LIMIT)); // R6
    AST_TOUCH_USE: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> use_vec[$past(touch_idx)]); // R9
    AST_TOUCH_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_valid && touch_write) |=> mod_vec[$past(touch_idx)]); // R2
endmodule

bind clk_repl_sel clk_repl_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_valid (touch_valid),
    .touch_idx   (touch_idx),
    .touch_write (touch_write),
    .req         (req),
    .busy        (busy),
    .done        (done),
    .victim_idx  (victim_idx),
    .hand_idx    (hand_idx),
    .use_vec     (use_vec),
    .mod_vec     (mod_vec)
);

// File: tb/sim_clk_repl_sel.sv
module sim_clk_repl_sel;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_valid = 1'b0;
    logic [IW-1:0] touch_idx = '0;
    logic          touch_write = 1'b0;
    logic          req = 1'b0;
    logic          busy, done, victim_dirty;
    logic [IW-1:0] victim_idx, hand_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    clk_repl_sel #(.NUM_FRAMES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_idx(touch_idx),
        .touch_write(touch_write), .req(req), .busy(busy), .done(done),
        .victim_idx(victim_idx), .victim_dirty(victim_dirty), .hand_idx(hand_idx)
    );

    // behavioural reference model
    int m_use[N];
    int m_mod[N];
    int m_hand, m_phase, m_steps, m_vidx, m_vdirty;
    bit m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_use[i] = 0; m_mod[i] = 0; end
            m_hand = 0; m_phase = 0; m_steps = 0; m_done = 0; m_vidx = 0; m_vdirty = 0;
        end else begin
            int clr_use, clr_vic;
            bit pick;
            clr_use = -1; clr_vic = -1;
            m_done = 0;
            if (m_phase == 0) begin
                if (req) begin m_phase = 1; m_steps = 0; end
            end else begin
                if (m_phase == 1)      pick = (m_use[m_hand] == 0) && (m_mod[m_hand] == 0);
                else if (m_phase == 2) pick = (m_use[m_hand] == 0);
                else                   pick = 1;
                if (pick) begin
                    m_done = 1; m_vidx = m_hand; m_vdirty = m_mod[m_hand];
                    clr_vic = m_hand; m_hand = (m_hand + 1) % N; m_phase = 0;
                end else begin
                    if (m_use[m_hand] != 0) clr_use = m_hand;
                    m_hand = (m_hand + 1) % N;
                    m_steps++;
                    if (m_steps == N) begin m_steps = 0; m_phase++; end
                end
            end
            if (clr_use >= 0) m_use[clr_use] = 0;
            if (clr_vic >= 0) begin m_use[clr_vic] = 0; m_mod[clr_vic] = 0; end
            if (touch_valid) begin
                m_use[touch_idx] = 1;
                if (touch_write) m_mod[touch_idx] = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (m_phase != 0), "R3 busy", busy, m_phase != 0);
            check(done == m_done, "R7 done", done, m_done);
            check(hand_idx == IW'(m_hand), "R7 hand", hand_idx, m_hand);
            if (m_done) begin
                check(victim_idx == IW'(m_vidx), "R4/R5 victim_idx", victim_idx, m_vidx);
                check(victim_dirty == m_vdirty[0], "R5 victim_dirty", victim_dirty, m_vdirty);
            end
        end
    end

    task automatic touch(input int idx, input bit wr);
        touch_valid = 1'b1; touch_idx = IW'(idx); touch_write = wr;
        @(negedge clk);
        touch_valid = 1'b0; touch_write = 1'b0;
    endtask

    task automatic wait_done(output int vi, output int vd);
        while (!done) @(negedge clk);
        vi = victim_idx; vd = victim_dirty;
        @(negedge clk);
    endtask

    task automatic scan(output int vi, output int vd);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        wait_done(vi, vd);
    endtask

    task automatic summary();
        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                summary();
            end
        end
    end

    initial begin
        int vi, vd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(hand_idx == 0, "R1 hand", hand_idx, 0);
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);

        // R4: all clean -> frame 0
        scan(vi, vd);
        check(vi == 0 && vd == 0, "R4 first victim", vi, 0);

        // R2/R4: frames 1,2 used, 3 written; 4 is first clean unused
        touch(1, 0); touch(2, 0); touch(3, 1);
        scan(vi, vd);
        check(vi == 4, "R2/R4 victim passes used frames", vi, 4);
        check(vd == 0, "R4 victim clean", vd, 0);

        // R5: every frame dirty -> second lap takes the start frame 5
        for (int i = 0; i < N; i++) touch(i, 1);
        scan(vi, vd);
        check(vi == 5, "R5 dirty fallback idx", vi, 5);
        check(vd == 1, "R5 dirty fallback flag", vd, 1);

        // R8: frame 5 was cleared at selection, so it is now the clean pick
        scan(vi, vd);
        check(vi == 5 && vd == 0, "R8 victim flags cleared", vi, 5);

        // R9: access on frame 6 at its inspection edge beats the scan clear
        touch(5, 1);
        touch(6, 0);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        touch_valid = 1'b1; touch_idx = 3'd6; touch_write = 1'b0;
        @(negedge clk);
        touch_valid = 1'b0;
        wait_done(vi, vd);
        check(vi == 7, "R9 access wins over clear", vi, 7);
        check(vd == 1, "R9 victim dirty", vd, 1);

        // R6: touching the hand's frame on every edge forces the fallback
        touch(7, 1);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int n = 0; n < 2 * N + 1; n++) begin
            touch_valid = 1'b1; touch_idx = IW'(n % N); touch_write = 1'b0;
            @(negedge clk);
        end
        touch_valid = 1'b0;
        check(done == 1'b1, "R6 forced pick done", done, 1);
        check(victim_idx == 0, "R6 forced pick idx", victim_idx, 0);
        check(victim_dirty == 1'b1, "R6 forced pick dirty", victim_dirty, 1);
        @(negedge clk);

        // R3: extra req while busy is ignored (model compare judges busy)
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_done(vi, vd);
        repeat (2) @(negedge clk);
        check(!busy, "R3 req during scan ignored", busy, 0);

        // mixed random traffic, judged by the per-cycle model
        for (int c = 0; c < 3000; c++) begin
            touch_valid = ($urandom_range(0, 2) != 0);
            touch_idx   = IW'($urandom_range(0, N - 1));
            touch_write = ($urandom_range(0, 3) == 0);
            req         = ($urandom_range(0, 5) == 0);
            @(negedge clk);
        end
        touch_valid = 1'b0; req = 1'b0;
        repeat (3 * N) @(negedge clk);
        summary();
    end
endmodule